// File: doc/BRIEF.md
# Transactional Footprint Conflict Tracker

This block records which cache lines one hardware transaction has touched and watches the probes that other agents send for those lines. While a transaction is running, each local load sets a read mark and each local store sets a write mark on an entry of a small fully associative table. Tags are kept per 64-byte line. When a remote probe reaches a marked line in a way that breaks isolation, the block raises a one-cycle abort request with a conflict cause. When a new line needs an entry and every entry is in use, it raises the request with an overflow cause.

The core drives a begin pulse to start a transaction, holds the active level for as long as it runs, and ends it with either a commit pulse or an abort pulse. Both pulses empty the table in one cycle. An abort pulse also produces a one-cycle rollback strobe, which the logic that discards speculative state uses. After an abort request the block stays silent until the next begin. Data buffering, the coherence protocol and the restoring of register state are handled outside this block.

Top module: `txn_footprint_tracker`

## Requirements
- R1: Lines are compared on address bits [31:6]. Addresses that differ only in bits [5:0] are the same line.
- R2: A remote write probe (rem_write=1) to a line with a local read mark gives abort_req=1 with abort_cause=2'b01 (conflict) in the cycle after the probe.
- R3: A remote read probe (rem_write=0) or a remote write probe to a line with a local write mark gives abort_req=1 with abort_cause=2'b01 in the cycle after the probe.
- R4: A remote read of a line that has only a read mark, and any probe to an untracked line, raise no abort.
- R5: The table holds 16 lines. A local access to a line already in the table reuses its entry. A local access to a 17th distinct line gives abort_req=1 with abort_cause=2'b10 (overflow) in the next cycle.
- R6: While txn_active is low, local accesses record no marks and no abort is ever raised.
- R7: A txn_commit pulse clears every entry. Probes after it find no marks, and the commit produces no rollback.
- R8: A txn_abort pulse clears every entry and makes rollback high for exactly the one following cycle.
- R9: abort_req lasts one cycle. After it, further conflicts and overflows are ignored until the next txn_begin.
- R10: When a remote probe and a local access to the same line arrive in the same cycle, the probe is checked against the marks held before that cycle. The local mark is recorded afterwards.
- R11: In a cycle with txn_begin, txn_commit or txn_abort high, probes and local accesses are ignored. txn_begin also clears the table.
- R12: abort_cause is 2'b00 whenever abort_req is low. Reset leaves abort_req, abort_cause and rollback low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_begin | input | 1 | Start-of-transaction pulse |
| txn_active | input | 1 | High while a transaction runs |
| txn_commit | input | 1 | Commit pulse; clears the table |
| txn_abort | input | 1 | Abort pulse; clears the table and requests rollback |
| loc_valid | input | 1 | Local access present |
| loc_write | input | 1 | Local access is a store (1) or a load (0) |
| loc_addr | input | 32 | Local access byte address |
| rem_valid | input | 1 | Remote probe present |
| rem_write | input | 1 | Remote probe is a write (1) or a read (0) |
| rem_addr | input | 32 | Remote probe byte address |
| abort_req | output | 1 | One-cycle abort request |
| abort_cause | output | 2 | 01 conflict, 10 overflow, 00 when no request |
| rollback | output | 1 | One-cycle strobe after txn_abort |

## Verification
A wrong mark, tag or valid bit inside the table shows up at the ports only when a later probe reaches that line. It appears as a missing or spurious abort_req one cycle after that probe. An allocation fault shows up either as an overflow before sixteen distinct lines are in use or as no overflow on the seventeenth. The sweeps therefore place every local access kind against every probe kind at several line offsets, fill the table to its limit, and probe again after each clearing event.

// File: rtl/txft_pkg.sv
package txft_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_CONFLICT = 2'b01,
    CAUSE_OVERFLOW = 2'b10
  } abort_cause_e;
endpackage

// File: rtl/txft_tag_table.sv
// Line-tag storage with separate read/write marks and parallel compare.
module txft_tag_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [TAG_W-1:0]   loc_tag,
  input  logic [TAG_W-1:0]   rem_tag,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               upd_rd,
  input  logic               upd_wr,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] rd_vec,
  output logic [ENTRIES-1:0] wr_vec,
  output logic [ENTRIES-1:0] loc_hit,
  output logic [ENTRIES-1:0] rem_hit
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, rd_q, wr_q;

  // Tag array: written only, never reset (valid bits qualify it).
  always_ff @(posedge clk) begin
    if (upd_en) tag_q[upd_idx] <= upd_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (upd_en) begin
      valid_q[upd_idx] <= 1'b1;
      rd_q[upd_idx]    <= rd_q[upd_idx] | upd_rd;
      wr_q[upd_idx]    <= wr_q[upd_idx] | upd_wr;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign loc_hit[g] = valid_q[g] && (tag_q[g] == loc_tag);
    assign rem_hit[g] = valid_q[g] && (tag_q[g] == rem_tag);
  end

  assign valid_vec = valid_q;
  assign rd_vec    = rd_q;
  assign wr_vec    = wr_q;
endmodule

// File: rtl/txft_access_eval.sv
// Decides conflict, overflow and the table update for one cycle.
module txft_access_eval #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               track_en,
  input  logic               loc_valid,
  input  logic               loc_write,
  input  logic               rem_valid,
  input  logic               rem_write,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] rd_vec,
  input  logic [ENTRIES-1:0] wr_vec,
  input  logic [ENTRIES-1:0] loc_hit,
  input  logic [ENTRIES-1:0] rem_hit,
  output logic               conflict,
  output logic               overflow,
  output logic               upd_en,
  output logic [IDX_W-1:0]   upd_idx,
  output logic               upd_rd,
  output logic               upd_wr
);
  logic [ENTRIES-1:0] guard_vec;
  logic               rem_conf, any_free, any_hit;
  logic [IDX_W-1:0]   free_idx, hit_idx;

  // Remote write collides with any mark; remote read only with a write mark.
  assign guard_vec = rem_write ? (rd_vec | wr_vec) : wr_vec;
  assign rem_conf  = rem_valid && |(rem_hit & guard_vec);
  assign any_hit   = |loc_hit;
  assign any_free  = ~&valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (loc_hit[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign conflict = track_en && rem_conf;
  assign overflow = track_en && !rem_conf && loc_valid && !any_hit && !any_free;
  assign upd_en   = track_en && !rem_conf && loc_valid && (any_hit || any_free);
  assign upd_idx  = any_hit ? hit_idx : free_idx;
  assign upd_rd   = !loc_write;
  assign upd_wr   = loc_write;
endmodule

// File: rtl/txn_footprint_tracker.sv
module txn_footprint_tracker #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int ENTRIES  = 16,
  localparam int TAG_W   = ADDR_W - LINE_OFS,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_begin,
  input  logic              txn_active,
  input  logic              txn_commit,
  input  logic              txn_abort,
  input  logic              loc_valid,
  input  logic              loc_write,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              rem_valid,
  input  logic              rem_write,
  input  logic [ADDR_W-1:0] rem_addr,
  output logic              abort_req,
  output logic [1:0]        abort_cause,
  output logic              rollback
);
  import txft_pkg::*;

  logic [TAG_W-1:0]   loc_tag, rem_tag;
  logic               ctl_busy, halted_q, track_en;
  logic [ENTRIES-1:0] valid_vec, rd_vec, wr_vec, loc_hit, rem_hit;
  logic               conflict, overflow, upd_en, upd_rd, upd_wr;
  logic [IDX_W-1:0]   upd_idx;
  logic               unused_ofs;

  assign loc_tag    = loc_addr[ADDR_W-1:LINE_OFS];
  assign rem_tag    = rem_addr[ADDR_W-1:LINE_OFS];
  assign unused_ofs = ^{loc_addr[LINE_OFS-1:0], rem_addr[LINE_OFS-1:0]};

  assign ctl_busy = txn_begin || txn_commit || txn_abort;
  assign track_en = txn_active && !halted_q && !ctl_busy;

  txft_tag_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst(rst), .clear(ctl_busy),
    .loc_tag(loc_tag), .rem_tag(rem_tag),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_tag(loc_tag),
    .upd_rd(upd_rd), .upd_wr(upd_wr),
    .valid_vec(valid_vec), .rd_vec(rd_vec), .wr_vec(wr_vec),
    .loc_hit(loc_hit), .rem_hit(rem_hit)
  );

  txft_access_eval #(.ENTRIES(ENTRIES)) u_eval (
    .track_en(track_en),
    .loc_valid(loc_valid), .loc_write(loc_write),
    .rem_valid(rem_valid), .rem_write(rem_write),
    .valid_vec(valid_vec), .rd_vec(rd_vec), .wr_vec(wr_vec),
    .loc_hit(loc_hit), .rem_hit(rem_hit),
    .conflict(conflict), .overflow(overflow),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_rd(upd_rd), .upd_wr(upd_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q    <= 1'b0;
      abort_req   <= 1'b0;
      abort_cause <= CAUSE_NONE;
      rollback    <= 1'b0;
    end else begin
      rollback  <= txn_abort;
      abort_req <= conflict || overflow;
      if (conflict)      abort_cause <= CAUSE_CONFLICT;
      else if (overflow) abort_cause <= CAUSE_OVERFLOW;
      else               abort_cause <= CAUSE_NONE;
      if (txn_begin)                 halted_q <= 1'b0;
      else if (conflict || overflow) halted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/txft_checker.sv
module txft_checker (
  input logic       clk,
  input logic       rst,
  input logic       txn_begin,
  input logic       txn_active,
  input logic       txn_commit,
  input logic       txn_abort,
  input logic       abort_req,
  input logic [1:0] abort_cause,
  input logic       rollback
);
  AST_CAUSE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    abort_req |-> $countones(abort_cause) == 1); // R2
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !abort_req |-> abort_cause == 2'b00); // R12
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req); // R9
  AST_NO_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !txn_active |=> !abort_req); // R6
  AST_CTL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (txn_begin || txn_commit || txn_abort) |=> !abort_req); // R11
  AST_COMMIT_NO_RB: assert property (@(posedge clk) disable iff (rst)
    (txn_commit && !txn_abort) |=> !rollback); // R7
  AST_RB_SHORT: assert property (@(posedge clk) disable iff (rst)
    (rollback && !txn_abort) |=> !rollback); // R8
endmodule

bind txn_footprint_tracker txft_checker u_chk (
  .clk(clk), .rst(rst), .txn_begin(txn_begin), .txn_active(txn_active),
  .txn_commit(txn_commit), .txn_abort(txn_abort), .abort_req(abort_req),
  .abort_cause(abort_cause), .rollback(rollback)
);

// File: tb/txn_footprint_tracker_tb.sv
module txn_footprint_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic txn_begin = 0, txn_active = 0, txn_commit = 0, txn_abort = 0;
  logic loc_valid = 0, loc_write = 0, rem_valid = 0, rem_write = 0;
  logic [31:0] loc_addr = '0, rem_addr = '0;
  logic abort_req, rollback;
  logic [1:0] abort_cause;

  int n_chk = 0, n_fail = 0;
  logic o_req, o_rb;
  logic [1:0] o_cause;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txn_footprint_tracker u_dut (
    .clk(clk), .rst(rst), .txn_begin(txn_begin), .txn_active(txn_active),
    .txn_commit(txn_commit), .txn_abort(txn_abort),
    .loc_valid(loc_valid), .loc_write(loc_write), .loc_addr(loc_addr),
    .rem_valid(rem_valid), .rem_write(rem_write), .rem_addr(rem_addr),
    .abort_req(abort_req), .abort_cause(abort_cause), .rollback(rollback)
  );

  function automatic logic [31:0] line_addr(int line, int ofs);
    return 32'h0004_0000 + 32'(line) * 32'd64 + 32'(ofs);
  endfunction

  // One cycle: drive at negedge, capture registered outputs at next negedge.
  task automatic cyc(input bit b, input bit c, input bit ab,
                     input bit lv, input bit lw, input logic [31:0] la,
                     input bit rv, input bit rw, input logic [31:0] ra);
    txn_begin = b; txn_commit = c; txn_abort = ab;
    loc_valid = lv; loc_write = lw; loc_addr = la;
    rem_valid = rv; rem_write = rw; rem_addr = ra;
    @(posedge clk);
    @(negedge clk);
    o_req = abort_req; o_cause = abort_cause; o_rb = rollback;
    txn_begin = 0; txn_commit = 0; txn_abort = 0; loc_valid = 0; rem_valid = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic chk(input string rq, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  // Expected {req, cause} packed as req*4 + cause.
  task automatic chk_abort(input string rq, input int exp);
    chk(rq, int'(o_req) * 4 + int'(o_cause), exp);
  endtask

  localparam int NONE = 0, CONF = 4 + 1, OVFL = 4 + 2;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    o_req = abort_req; o_cause = abort_cause; o_rb = rollback;
    chk_abort("R12 reset", NONE);
    chk("R12 reset rollback", int'(o_rb), 0);

    txn_active = 1;
    // R1 R2 R3 R4: local kind x probe kind x offset x same/other line.
    for (int lk = 0; lk < 2; lk++)
      for (int rk = 0; rk < 2; rk++)
        for (int ofs = 0; ofs < 64; ofs += 21)
          for (int same = 0; same < 2; same++) begin
            cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
            cyc(0, 0, 0, 1, lk[0], line_addr(3, 63 - ofs), 0, 0, '0);
            chk_abort("R1 local access", NONE);
            cyc(0, 0, 0, 0, 0, '0, 1, rk[0], line_addr(same != 0 ? 3 : 4, ofs));
            chk_abort("R2/R3/R4 probe",
                      (same != 0 && (rk != 0 || lk != 0)) ? CONF : NONE);
            cyc(0, 0, 1, 0, 0, '0, 0, 0, '0);
            chk("R8 rollback", int'(o_rb), 1);
          end

    // R5: fill, revisit, overflow; R9: silent afterwards.
    cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
    for (int i = 0; i < LINES; i++) begin
      cyc(0, 0, 0, 1, 0, line_addr(10 + i, 0), 0, 0, '0);
      chk_abort("R5 fill", NONE);
    end
    for (int i = 0; i < LINES; i++) begin
      cyc(0, 0, 0, 1, 1, line_addr(10 + i, 17), 0, 0, '0);
      chk_abort("R5 reuse", NONE);
    end
    cyc(0, 0, 0, 1, 0, line_addr(40, 0), 0, 0, '0);
    chk_abort("R5 overflow", OVFL);
    idle();
    chk_abort("R9 one cycle", NONE);
    cyc(0, 0, 0, 0, 0, '0, 1, 1, line_addr(10, 0));
    chk_abort("R9 silenced", NONE);
    cyc(1, 0, 0, 0, 0, '0, 1, 1, line_addr(10, 0));
    chk_abort("R11 begin ignores probe", NONE);
    cyc(0, 0, 0, 0, 0, '0, 1, 0, line_addr(12, 0));
    chk_abort("R11 begin cleared table", NONE);
    cyc(0, 0, 0, 1, 0, line_addr(10, 0), 0, 0, '0);
    cyc(0, 0, 0, 0, 0, '0, 1, 1, line_addr(10, 8));
    chk_abort("R9 rearmed after begin", CONF);
    cyc(0, 0, 0, 0, 0, '0, 1, 1, line_addr(10, 8));
    chk_abort("R9 second conflict ignored", NONE);

    // R6: nothing recorded, nothing raised while inactive.
    cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
    txn_active = 0;
    for (int i = 0; i < LINES + 2; i++) begin
      cyc(0, 0, 0, 1, 1, line_addr(50 + i, 0), 1, 1, line_addr(50 + i, 0));
      chk_abort("R6 inactive", NONE);
    end
    txn_active = 1;
    cyc(0, 0, 0, 0, 0, '0, 1, 1, line_addr(50, 0));
    chk_abort("R6 no mark recorded", NONE);

    // R7: commit clears, no rollback; R11 commit cycle ignores probe.
    cyc(0, 0, 0, 1, 1, line_addr(60, 0), 0, 0, '0);
    cyc(0, 1, 0, 0, 0, '0, 1, 1, line_addr(60, 0));
    chk_abort("R11 commit ignores probe", NONE);
    chk("R7 no rollback", int'(o_rb), 0);
    cyc(0, 0, 0, 0, 0, '0, 1, 0, line_addr(60, 0));
    chk_abort("R7 cleared", NONE);

    // R8: abort clears, rollback exactly one cycle.
    cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 1, line_addr(61, 0), 0, 0, '0);
    cyc(0, 0, 1, 0, 0, '0, 0, 0, '0);
    chk("R8 rollback high", int'(o_rb), 1);
    idle();
    chk("R8 rollback low", int'(o_rb), 0);
    cyc(0, 0, 0, 0, 0, '0, 1, 0, line_addr(61, 0));
    chk_abort("R8 cleared", NONE);

    // R10: same-cycle probe sees old marks only.
    cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 0, line_addr(70, 4), 1, 1, line_addr(70, 9));
    chk_abort("R10 read+remote write same cycle", NONE);
    cyc(0, 0, 0, 0, 0, '0, 1, 1, line_addr(70, 0));
    chk_abort("R10 mark recorded after", CONF);
    cyc(1, 0, 0, 0, 0, '0, 0, 0, '0);
    cyc(0, 0, 0, 1, 1, line_addr(71, 0), 1, 0, line_addr(71, 0));
    chk_abort("R10 write+remote read same cycle", NONE);
    cyc(0, 0, 0, 0, 0, '0, 1, 0, line_addr(71, 0));
    chk_abort("R10 write mark recorded after", CONF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule